// File: doc/BRIEF.md
# Boot-Capable ROM Access Controller

This block decodes accesses on a simple synchronous bus for an on-chip read-only array and a small control-register block. Right after reset it can also act as the first code source of the system. In that role it answers a few fixed low addresses with 16-bit words taken from bootstrap data inputs. Once the last of those words has been read, the bootstrap window closes by itself and stays closed until the next reset.

Each access is presented for one cycle with `req_i` and its attributes: address, write flag, byte/word size, supervisor/user and program/data. The block answers one cycle later with `ack_o` and the read data. An access that the block does not claim gets no acknowledge, so another device can answer it.

The array occupies a power-of-two block at a base address. Only its first `arr_words_i` words are populated, and the rest of the block is left unclaimed for a neighbouring device. The array can be limited to supervisor reads, to program-space reads, or to both. A stop input removes the array and the bootstrap window from the map. The control block remains reachable while stop is set, so software can clear it.

Top module: `boot_rom_ctrl`

## Requirements
- R1: During reset `ack_o` is 0. The bootstrap flag is set at reset only if `boot_en_n_i` is 0 and `stop_i` is 0 at that time.
- R2: While the bootstrap flag is set, a supervisor program-space read of address BOOT_BASE+2k is acknowledged with word k, which is `boot_data_i[16k+15:16k]`. Reads in user mode, reads in data space and writes to these addresses are not acknowledged, and neither is the array.
- R3: The final bootstrap word is word 1 when `long_boot_i` is 0 and word 3 when it is 1. A claimed read of the final word clears the flag, and the array answers from the next access on. In short mode, words 2 and 3 are not claimed.
- R4: If stop is 1 at reset, bootstrap stays off. Clearing stop afterwards never turns it on.
- R5: While `stop_i` is 1, array and bootstrap accesses are not acknowledged.
- R6: Any access, read or write, to the CTRL_BYTES control block at CTRL_BASE is always acknowledged. A read returns the status word with bit 3 set to the bootstrap flag, bit 2 to stop, bit 1 to the supervisor-only control, bit 0 to the program-only control, and all other bits 0. Writes change nothing.
- R7: An array word read at offset 2i returns {i[7:0]^8'h5A, ~i[7:0]}. For a byte read (`size_i`=0), the even address gives the high byte and the odd address gives the low byte, in `rdata_o[7:0]` with the upper bits 0.
- R8: Writes to the array are not acknowledged.
- R9: When `priv_only_i` is 1, user-mode array reads are not acknowledged and supervisor reads are. When it is 0, both are acknowledged.
- R10: When `prog_only_i` is 1, data-space array reads are not acknowledged. When it is 0, both spaces are acknowledged.
- R11: Offsets at or beyond 2*`arr_words_i` inside the array block, and addresses outside the block, are not acknowledged.
- R12: `ack_o` rises exactly one cycle after a claimed request. When `ack_o` is 0, or when the access was a write, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request, one cycle |
| addr_i | input | ADDR_W | Byte address |
| write_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 1 | 1 = word, 0 = byte |
| super_i | input | 1 | 1 = supervisor, 0 = user |
| prog_i | input | 1 | 1 = program space, 0 = data space |
| rdata_o | output | 16 | Read data, valid with ack_o |
| ack_o | output | 1 | Access claimed |
| boot_en_n_i | input | 1 | Bootstrap enable, active low, sampled at reset |
| stop_i | input | 1 | Stop control |
| long_boot_i | input | 1 | 1 = four bootstrap words, 0 = two |
| boot_data_i | input | 64 | Four bootstrap words, word k at bits 16k+15:16k |
| arr_base_i | input | ADDR_W | Array block base address |
| arr_words_i | input | BLK_W | Number of populated array words |
| priv_only_i | input | 1 | Array answers supervisor reads only |
| prog_only_i | input | 1 | Array answers program-space reads only |

## Verification
A bootstrap flag stuck at 1 blocks the array, and one stuck at 0 loses the boot words. Either fault shows in the status word and in the acknowledge of the very next access. If the flag fails to clear, the next array read after the final boot word goes unacknowledged, one cycle after that read is issued. Decode faults in the gap, in the attribute filters or in the stop gating show up as a wrong `ack_o` one cycle after the offending request.

// File: rtl/boot_rom_pkg.sv
package boot_rom_pkg;

    typedef enum logic [1:0] {
        REG_NONE  = 2'd0,
        REG_CTRL  = 2'd1,
        REG_BOOT  = 2'd2,
        REG_ARRAY = 2'd3
    } region_e;

    localparam int WORD_W = 16;

    function automatic logic [15:0] rom_word(input logic [7:0] idx);
        return {idx ^ 8'h5A, ~idx};
    endfunction

    function automatic logic [15:0] lane_pick(input logic [15:0] w,
                                              input logic        byte_acc,
                                              input logic        odd);
        if (!byte_acc)
            return w;
        return odd ? {8'h00, w[7:0]} : {8'h00, w[15:8]};
    endfunction

endpackage

// File: rtl/rom_decode.sv
module rom_decode
    import boot_rom_pkg::*;
#(
    parameter int          ADDR_W     = 24,
    parameter int          BLK_W      = 8,
    parameter int          CTRL_W     = 4,
    parameter logic [23:0] CTRL_BASE  = 24'hFFF800,
    parameter logic [23:0] BOOT_BASE  = 24'h000000
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              write_i,
    input  logic              super_i,
    input  logic              prog_i,
    input  logic              boot_active,
    input  logic              stop_i,
    input  logic              long_boot_i,
    input  logic [ADDR_W-1:0] arr_base_i,
    input  logic [BLK_W-1:0]  arr_words_i,
    input  logic              priv_only_i,
    input  logic              prog_only_i,
    output region_e           region_o,
    output logic [1:0]        boot_idx_o,
    output logic [BLK_W-2:0]  word_idx_o
);
    localparam logic [ADDR_W-1:0] CTRL_B = CTRL_BASE[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] BOOT_B = BOOT_BASE[ADDR_W-1:0];

    logic             ctrl_hit, boot_hit, arr_hit;
    logic [BLK_W:0]   limit;
    logic [BLK_W-1:0] offs;

    always_comb begin
        offs  = addr_i[BLK_W-1:0];
        limit = {arr_words_i, 1'b0};

        ctrl_hit = addr_i[ADDR_W-1:CTRL_W] == CTRL_B[ADDR_W-1:CTRL_W];

        boot_hit = boot_active && !stop_i && !write_i && super_i && prog_i
                && (addr_i[ADDR_W-1:3] == BOOT_B[ADDR_W-1:3])
                && (long_boot_i || !addr_i[2]);

        arr_hit = !boot_active && !stop_i && !write_i
               && (addr_i[ADDR_W-1:BLK_W] == arr_base_i[ADDR_W-1:BLK_W])
               && ({1'b0, offs} < limit)
               && (super_i || !priv_only_i)
               && (prog_i || !prog_only_i);

        if (ctrl_hit)      region_o = REG_CTRL;
        else if (boot_hit) region_o = REG_BOOT;
        else if (arr_hit)  region_o = REG_ARRAY;
        else               region_o = REG_NONE;

        boot_idx_o = addr_i[2:1];
        word_idx_o = offs[BLK_W-1:1];
    end
endmodule

// File: rtl/rom_boot_seq.sv
module rom_boot_seq (
    input  logic clk,
    input  logic rst,
    input  logic boot_en_n_i,
    input  logic stop_i,
    input  logic last_fetch,
    output logic boot_active
);
    always_ff @(posedge clk) begin
        if (rst)
            boot_active <= !boot_en_n_i && !stop_i;
        else if (last_fetch)
            boot_active <= 1'b0;
    end
endmodule

// File: rtl/rom_array.sv
module rom_array
    import boot_rom_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [15:0]      word_q
);
    logic [7:0] idx8;

    generate
        if (IDX_W >= 8) begin : g_trunc
            assign idx8 = idx[7:0];
        end else begin : g_ext
            assign idx8 = {{(8-IDX_W){1'b0}}, idx};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (en)
            word_q <= rom_word(idx8);
    end
endmodule

// File: rtl/boot_rom_ctrl.sv
module boot_rom_ctrl
    import boot_rom_pkg::*;
#(
    parameter int          ADDR_W      = 24,
    parameter int          BLOCK_BYTES = 256,
    parameter int          CTRL_BYTES  = 16,
    parameter logic [23:0] CTRL_BASE   = 24'hFFF800,
    parameter logic [23:0] BOOT_BASE   = 24'h000000,
    localparam int         BLK_W       = $clog2(BLOCK_BYTES),
    localparam int         CTRL_W      = $clog2(CTRL_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              write_i,
    input  logic              size_i,
    input  logic              super_i,
    input  logic              prog_i,
    output logic [15:0]       rdata_o,
    output logic              ack_o,
    input  logic              boot_en_n_i,
    input  logic              stop_i,
    input  logic              long_boot_i,
    input  logic [63:0]       boot_data_i,
    input  logic [ADDR_W-1:0] arr_base_i,
    input  logic [BLK_W-1:0]  arr_words_i,
    input  logic              priv_only_i,
    input  logic              prog_only_i
);
    region_e          region, region_q;
    logic [1:0]       boot_idx;
    logic [BLK_W-2:0] word_idx;
    logic             boot_active, last_fetch, claim;
    logic             ack_q, rd_q, lane_q, byte_q;
    logic [15:0]      held_q, arr_word, status, boot_word, word_sel;

    rom_decode #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W), .CTRL_W(CTRL_W),
        .CTRL_BASE(CTRL_BASE), .BOOT_BASE(BOOT_BASE)
    ) dec_i (
        .addr_i(addr_i), .write_i(write_i), .super_i(super_i), .prog_i(prog_i),
        .boot_active(boot_active), .stop_i(stop_i), .long_boot_i(long_boot_i),
        .arr_base_i(arr_base_i), .arr_words_i(arr_words_i),
        .priv_only_i(priv_only_i), .prog_only_i(prog_only_i),
        .region_o(region), .boot_idx_o(boot_idx), .word_idx_o(word_idx)
    );

    assign claim      = req_i && (region != REG_NONE);
    assign last_fetch = req_i && (region == REG_BOOT)
                     && (boot_idx == (long_boot_i ? 2'd3 : 2'd1));

    rom_boot_seq seq_i (
        .clk(clk), .rst(rst), .boot_en_n_i(boot_en_n_i), .stop_i(stop_i),
        .last_fetch(last_fetch), .boot_active(boot_active)
    );

    rom_array #(.IDX_W(BLK_W-1)) arr_i (
        .clk(clk), .en(req_i && region == REG_ARRAY),
        .idx(word_idx), .word_q(arr_word)
    );

    assign status    = {12'h000, boot_active, stop_i, priv_only_i, prog_only_i};
    assign boot_word = boot_data_i[boot_idx*16 +: 16];

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q    <= 1'b0;
            rd_q     <= 1'b0;
            region_q <= REG_NONE;
            lane_q   <= 1'b0;
            byte_q   <= 1'b0;
            held_q   <= '0;
        end else begin
            ack_q    <= claim;
            rd_q     <= claim && !write_i;
            region_q <= region;
            lane_q   <= addr_i[0];
            byte_q   <= !size_i;
            held_q   <= (region == REG_CTRL) ? status : boot_word;
        end
    end

    always_comb begin
        word_sel = (region_q == REG_ARRAY) ? arr_word : held_q;
        rdata_o  = rd_q ? lane_pick(word_sel, byte_q, lane_q) : 16'h0000;
        ack_o    = ack_q;
    end
endmodule

// File: rtl/boot_rom_checker.sv
module boot_rom_checker #(
    parameter int          ADDR_W    = 24,
    parameter int          CTRL_W    = 4,
    parameter logic [23:0] CTRL_BASE = 24'hFFF800
) (
    input logic              clk,
    input logic              rst,
    input logic              req_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              write_i,
    input logic              super_i,
    input logic              stop_i,
    input logic              priv_only_i,
    input logic              ack_o,
    input logic              boot_active
);
    localparam logic [ADDR_W-1:0] CB = CTRL_BASE[ADDR_W-1:0];
    logic in_ctrl;
    assign in_ctrl = addr_i[ADDR_W-1:CTRL_W] == CB[ADDR_W-1:CTRL_W];

    assert_ack_after_req_R12: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> $past(req_i));

    assert_stop_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (ack_o && $past(stop_i)) |-> $past(in_ctrl));

    assert_boot_never_rises_R4: assert property (@(posedge clk) disable iff (rst)
        boot_active |-> $past(boot_active));

    assert_no_array_write_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_o && $past(write_i)) |-> $past(in_ctrl));

    assert_user_filtered_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_o && $past(priv_only_i) && !$past(super_i)) |-> $past(in_ctrl));

    assert_ctrl_claimed_R6: assert property (@(posedge clk) disable iff (rst)
        (req_i && in_ctrl) |=> ack_o);
endmodule

bind boot_rom_ctrl boot_rom_checker #(
    .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .CTRL_BASE(CTRL_BASE)
) chk_i (
    .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i), .write_i(write_i),
    .super_i(super_i), .stop_i(stop_i), .priv_only_i(priv_only_i),
    .ack_o(ack_o), .boot_active(boot_active)
);

// File: tb/boot_rom_ctrl_tb.sv
module boot_rom_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_i, write_i, size_i, super_i, prog_i;
    logic [23:0] addr_i;
    logic [15:0] rdata_o;
    logic        ack_o;
    logic        boot_en_n_i, stop_i, long_boot_i, priv_only_i, prog_only_i;
    logic [63:0] boot_data_i;
    logic [23:0] arr_base_i;
    logic [7:0]  arr_words_i;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic got_ack;
    logic [15:0] got_data;

    always #4 clk = ~clk;

    boot_rom_ctrl dut_i (
        .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i), .write_i(write_i),
        .size_i(size_i), .super_i(super_i), .prog_i(prog_i), .rdata_o(rdata_o),
        .ack_o(ack_o), .boot_en_n_i(boot_en_n_i), .stop_i(stop_i),
        .long_boot_i(long_boot_i), .boot_data_i(boot_data_i),
        .arr_base_i(arr_base_i), .arr_words_i(arr_words_i),
        .priv_only_i(priv_only_i), .prog_only_i(prog_only_i)
    );

    // fields: addr[44:21] wr[20] word[19] sup[18] prog[17] ack[16] data[15:0]
    localparam logic [44:0] VEC [13] = '{
        {24'h010000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h5AFF},
        {24'h010002, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h5BFE},
        {24'h010003, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h00FE},
        {24'h010002, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h005B},
        {24'h01007E, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h65C0},
        {24'h010080, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000},
        {24'h0100FE, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000},
        {24'h010100, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000},
        {24'h010000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000},
        {24'h010004, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h58FD},
        {24'hFFF800, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000},
        {24'hFFF802, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0000},
        {24'h000000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000}
    };

    task automatic check(input string req, input logic a, input logic [15:0] d,
                         input logic ea, input logic [15:0] ed);
        checks++;
        if (a !== ea || d !== ed) begin
            fails++;
            $display("FAIL %s: ack=%0b data=%h expected ack=%0b data=%h",
                     req, a, d, ea, ed);
        end
    endtask

    task automatic access(input logic [23:0] a, input logic wr, input logic wd,
                          input logic sup, input logic prg);
        @(negedge clk);
        req_i = 1'b1; addr_i = a; write_i = wr; size_i = wd;
        super_i = sup; prog_i = prg;
        @(negedge clk);
        req_i = 1'b0;
        got_ack = ack_o; got_data = rdata_o;
    endtask

    task automatic do_reset(input logic ben_n, input logic stp, input logic lng);
        @(negedge clk);
        boot_en_n_i = ben_n; stop_i = stp; long_boot_i = lng;
        rst = 1'b1; req_i = 1'b0;
        @(negedge clk);
        check("R1 reset ack", ack_o, rdata_o, 1'b0, 16'h0000);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic status(input string req, input logic [15:0] exp);
        access(24'hFFF800, 1'b0, 1'b1, 1'b0, 1'b0);
        check(req, got_ack, got_data, 1'b1, exp);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                fails++;
                $display("FAIL watchdog: ack=%0b data=%h expected ack=x data=x",
                         ack_o, rdata_o);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; req_i = 1'b0; addr_i = '0; write_i = 1'b0; size_i = 1'b1;
        super_i = 1'b1; prog_i = 1'b1;
        boot_en_n_i = 1'b1; stop_i = 1'b0; long_boot_i = 1'b0;
        priv_only_i = 1'b0; prog_only_i = 1'b0;
        boot_data_i = 64'h1111_2222_3333_4444;
        arr_base_i = 24'h010000; arr_words_i = 8'd64;

        // table walk: R7 R8 R11 R12 R6 R2
        do_reset(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 13; i++) begin
            access(VEC[i][44:21], VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17]);
            check("R7/R8/R11/R12/R6 vector", got_ack, got_data, VEC[i][16], VEC[i][15:0]);
        end
        @(negedge clk);
        check("R12 idle", ack_o, rdata_o, 1'b0, 16'h0000);

        // R9 supervisor-only
        priv_only_i = 1'b1;
        access(24'h010000, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R9 user blocked", got_ack, got_data, 1'b0, 16'h0000);
        access(24'h010000, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R9 super ok", got_ack, got_data, 1'b1, 16'h5AFF);
        status("R6 status priv", 16'h0002);
        priv_only_i = 1'b0;

        // R10 program-only
        prog_only_i = 1'b1;
        access(24'h010002, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R10 data blocked", got_ack, got_data, 1'b0, 16'h0000);
        access(24'h010002, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R10 program ok", got_ack, got_data, 1'b1, 16'h5BFE);
        prog_only_i = 1'b0;

        // R5 stop
        stop_i = 1'b1;
        access(24'h010000, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R5 array stopped", got_ack, got_data, 1'b0, 16'h0000);
        status("R6 status stop", 16'h0004);
        stop_i = 1'b0;

        // R2 R3 short bootstrap
        do_reset(1'b0, 1'b0, 1'b0);
        status("R1 boot flag set", 16'h0008);
        access(24'h010000, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R2 array hidden in boot", got_ack, got_data, 1'b0, 16'h0000);
        access(24'h000000, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R2 user boot blocked", got_ack, got_data, 1'b0, 16'h0000);
        access(24'h000000, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R2 data boot blocked", got_ack, got_data, 1'b0, 16'h0000);
        access(24'h000004, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R3 short word2 unclaimed", got_ack, got_data, 1'b0, 16'h0000);
        access(24'h000000, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R2 word0", got_ack, got_data, 1'b1, 16'h4444);
        access(24'h000002, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R3 final word1", got_ack, got_data, 1'b1, 16'h3333);
        status("R3 flag cleared", 16'h0000);
        access(24'h000000, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R3 boot closed", got_ack, got_data, 1'b0, 16'h0000);
        access(24'h010000, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R3 array open", got_ack, got_data, 1'b1, 16'h5AFF);

        // R3 long bootstrap
        do_reset(1'b0, 1'b0, 1'b1);
        access(24'h000002, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R3 long word1", got_ack, got_data, 1'b1, 16'h3333);
        status("R3 long still active", 16'h0008);
        access(24'h000004, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R3 long word2", got_ack, got_data, 1'b1, 16'h2222);
        access(24'h000007, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R3 long word3 byte", got_ack, got_data, 1'b1, 16'h0011);
        status("R3 long ended", 16'h0000);

        // R4 stop at reset
        do_reset(1'b0, 1'b1, 1'b0);
        status("R4 stop at reset", 16'h0004);
        stop_i = 1'b0;
        access(24'h000000, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R4 no late boot", got_ack, got_data, 1'b0, 16'h0000);
        status("R4 flag stays off", 16'h0000);

        // R5 stop during bootstrap
        do_reset(1'b0, 1'b0, 1'b0);
        stop_i = 1'b1;
        access(24'h000000, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R5 boot stopped", got_ack, got_data, 1'b0, 16'h0000);
        status("R5 status", 16'h000C);
        stop_i = 1'b0;
        access(24'h000000, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R2 boot resumes", got_ack, got_data, 1'b1, 16'h4444);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule